// File: doc/BRIEF.md
# Two-Class Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt requests and presents them to a processor on two lines: a normal request line and a fast request line. Each source has its own enable bit, a class bit that selects which line it drives, and a 4-bit priority. A request can come from the source input or from a software force bit. All of this is programmed over a simple 32-bit register bus. The bus has a byte address, write data, a write strobe and a combinational read-data return.

On the normal class, an arbiter picks the pending source with the highest priority. A programmable priority floor can mask out lower levels. When two sources have the same priority, the higher-numbered source wins. Software reads the normal vector word to get the number of the winning source. Because the sources are level-sensitive, the handler services the winner and reads the vector again. It keeps doing this until the word shows the all-ones "nothing pending" code. The fast class has no priority scheme: its vector word reports the highest-numbered pending fast source.

Top module: `dual_class_intc`

## Requirements
- R1: After reset, the enable, class, force and priority state is all zero and the mask register (0x04) reads 0x1F. Both vector words (0x40, 0x44) read 0xFFFF0000, and normal_irq and fast_irq are low.
- R2: Writing a value N below 64 to 0x08 sets the enable bit of source N, and writing N to 0x0C clears it. Values of 64 or more are ignored. The enable bits for sources 0-31 are at 0x14 and those for sources 32-63 are at 0x10; in both words bit i is source 32*h+i.
- R3: A class bit of 1 sends its source to the fast line, and 0 sends it to the normal line. The class bits for sources 0-31 are at 0x1C and those for sources 32-63 are at 0x18. No source is ever pending on both lines.
- R4: The request of a source is its input OR its force bit. The force bits for sources 0-31 are at 0x54 and those for sources 32-63 are at 0x50. The raw-input words 0x4C (low) and 0x48 (high) show the inputs only, not the force bits.
- R5: The normal pending words 0x5C (low) and 0x58 (high) read request AND enable AND NOT class, whatever the mask level. The fast pending words 0x64 (low) and 0x60 (high) read request AND enable AND class.
- R6: Priority word x (x = 0..7) sits at byte offset 0x20 + 4*(7-x). Bits 4k+3:4k of that word hold the priority of source 8x+k.
- R7: The normal vector word 0x40 carries the number of the winning eligible normal source in bits 31:16, and bits 15:0 read 0. The winner is the source with the highest priority; on equal priority the higher number wins. With no eligible source, bits 31:16 read 0xFFFF.
- R8: When mask bit 4 is set, every priority level is eligible. Otherwise a normal pending source is eligible only if its priority is strictly greater than mask bits 3:0. normal_irq is high exactly when some source is eligible.
- R9: fast_irq is high whenever any fast pending bit is set. The fast vector word 0x44 carries the highest-numbered fast pending source in bits 31:16, or 0xFFFF when none is pending.
- R10: The outputs and vector words follow the source inputs in the same cycle, with no stored edge. A request that drops leaves no trace. Register writes take effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level-sensitive interrupt inputs, bit n is source n |
| bus_addr | input | 7 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, captured at the rising clock edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| normal_irq | output | 1 | Normal-class interrupt request |
| fast_irq | output | 1 | Fast-class interrupt request |

## Verification
The bound checker watches several properties on every cycle:
- normal_irq agrees with the arbiter's valid flag, and fast_irq agrees with the fast finder.
- Each reported winner is actually pending in its class.
- No source is pending in both classes.
- A winner below or equal to the mask floor is never reported.
- An enable-by-number or disable-by-number write lands on the addressed bit at the next edge.

Some behaviour only the directed scenarios can show, because it depends on chosen values:
- the address mapping of the priority words;
- the tie-break toward the higher number;
- out-of-range numbers being ignored;
- force bits staying out of the raw-input words;
- the vector returning to 0xFFFF once a level drops.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC   = 64;
  localparam int PRIO_W    = 4;
  localparam int NUM_W     = $clog2(NUM_SRC);
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 32;
  localparam int MASK_W    = PRIO_W + 1;
  localparam logic [15:0] VEC_NONE = 16'hFFFF;

  // word indices (byte address >> 2)
  localparam logic [4:0] W_MASK   = 5'h01;
  localparam logic [4:0] W_ENNUM  = 5'h02;
  localparam logic [4:0] W_DISNUM = 5'h03;
  localparam logic [4:0] W_ENHI   = 5'h04;
  localparam logic [4:0] W_ENLO   = 5'h05;
  localparam logic [4:0] W_CLSHI  = 5'h06;
  localparam logic [4:0] W_CLSLO  = 5'h07;
  localparam logic [4:0] W_NVEC   = 5'h10;
  localparam logic [4:0] W_FVEC   = 5'h11;
  localparam logic [4:0] W_SRCHI  = 5'h12;
  localparam logic [4:0] W_SRCLO  = 5'h13;
  localparam logic [4:0] W_FRCHI  = 5'h14;
  localparam logic [4:0] W_FRCLO  = 5'h15;
  localparam logic [4:0] W_NPHI   = 5'h16;
  localparam logic [4:0] W_NPLO   = 5'h17;
  localparam logic [4:0] W_FPHI   = 5'h18;
  localparam logic [4:0] W_FPLO   = 5'h19;
endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_SRC-1:0]         en_q,
  output logic [NUM_SRC-1:0]         cls_q,
  output logic [NUM_SRC-1:0]         frc_q,
  output logic [MASK_W-1:0]          mask_q,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_q
);
  logic [NUM_SRC-1:0]        en_d, cls_d, frc_d;
  logic [MASK_W-1:0]         mask_d;
  logic [NUM_SRC*PRIO_W-1:0] prio_d;
  logic                      num_ok;

  assign num_ok = (wdata[DATA_W-1:NUM_W] == '0);

  always_comb begin
    en_d   = en_q;
    cls_d  = cls_q;
    frc_d  = frc_q;
    mask_d = mask_q;
    prio_d = prio_q;
    if (we) begin
      case (addr[ADDR_W-1:2])
        W_MASK:   mask_d = wdata[MASK_W-1:0];
        W_ENNUM:  if (num_ok) en_d[wdata[NUM_W-1:0]] = 1'b1;
        W_DISNUM: if (num_ok) en_d[wdata[NUM_W-1:0]] = 1'b0;
        W_ENHI:   en_d[63:32]  = wdata;
        W_ENLO:   en_d[31:0]   = wdata;
        W_CLSHI:  cls_d[63:32] = wdata;
        W_CLSLO:  cls_d[31:0]  = wdata;
        W_FRCHI:  frc_d[63:32] = wdata;
        W_FRCLO:  frc_d[31:0]  = wdata;
        5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0E, 5'h0F:
          // word x lives at index 15-x, so x is the inverted low bits
          prio_d[{~addr[4:2], 5'd0} +: DATA_W] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cls_q  <= '0;
      frc_q  <= '0;
      mask_q <= {MASK_W{1'b1}};
      prio_q <= '0;
    end else if (we) begin
      en_q   <= en_d;
      cls_q  <= cls_d;
      frc_q  <= frc_d;
      mask_q <= mask_d;
      prio_q <= prio_d;
    end
  end
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
  import intc_pkg::*;
(
  input  logic [NUM_SRC-1:0]        elig,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  output logic                      valid,
  output logic [NUM_W-1:0]          num
);
  logic [PRIO_W-1:0] best;

  // ascending scan with >= lets the higher number win a tie
  always_comb begin
    valid = 1'b0;
    best  = '0;
    num   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!valid || prio[i*PRIO_W +: PRIO_W] >= best)) begin
        valid = 1'b1;
        best  = prio[i*PRIO_W +: PRIO_W];
        num   = NUM_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_top_find.sv
module intc_top_find #(
  parameter int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dual_class_intc.sv
module dual_class_intc
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       src_i,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              normal_irq,
  output logic              fast_irq
);
  logic [NUM_SRC-1:0]        en_q, cls_q, frc_q, req;
  logic [NUM_SRC-1:0]        norm_pend, fast_pend, elig;
  logic [MASK_W-1:0]         mask_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic                      nvec_valid, fvec_valid;
  logic [NUM_W-1:0]          nvec_num, fvec_num;
  logic [DATA_W-1:0]         nvec_word, fvec_word;

  intc_regfile u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .en_q   (en_q),
    .cls_q  (cls_q),
    .frc_q  (frc_q),
    .mask_q (mask_q),
    .prio_q (prio_q)
  );

  assign req       = src_i | frc_q;
  assign norm_pend = req & en_q & ~cls_q;
  assign fast_pend = req & en_q & cls_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = norm_pend[g] &
                     (mask_q[PRIO_W] | (prio_q[g*PRIO_W +: PRIO_W] > mask_q[PRIO_W-1:0]));
  end

  assign normal_irq = |elig;
  assign fast_irq   = |fast_pend;

  intc_prio_arb u_arb (
    .elig  (elig),
    .prio  (prio_q),
    .valid (nvec_valid),
    .num   (nvec_num)
  );

  intc_top_find #(.W(NUM_SRC)) u_fast (
    .vec   (fast_pend),
    .valid (fvec_valid),
    .idx   (fvec_num)
  );

  assign nvec_word = nvec_valid ? {{(16-NUM_W){1'b0}}, nvec_num, 16'h0000} : {VEC_NONE, 16'h0000};
  assign fvec_word = fvec_valid ? {{(16-NUM_W){1'b0}}, fvec_num, 16'h0000} : {VEC_NONE, 16'h0000};

  always_comb begin
    case (bus_addr[ADDR_W-1:2])
      W_MASK:  bus_rdata = {{(DATA_W-MASK_W){1'b0}}, mask_q};
      W_ENHI:  bus_rdata = en_q[63:32];
      W_ENLO:  bus_rdata = en_q[31:0];
      W_CLSHI: bus_rdata = cls_q[63:32];
      W_CLSLO: bus_rdata = cls_q[31:0];
      5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0E, 5'h0F:
               bus_rdata = prio_q[{~bus_addr[4:2], 5'd0} +: DATA_W];
      W_NVEC:  bus_rdata = nvec_word;
      W_FVEC:  bus_rdata = fvec_word;
      W_SRCHI: bus_rdata = src_i[63:32];
      W_SRCLO: bus_rdata = src_i[31:0];
      W_FRCHI: bus_rdata = frc_q[63:32];
      W_FRCLO: bus_rdata = frc_q[31:0];
      W_NPHI:  bus_rdata = norm_pend[63:32];
      W_NPLO:  bus_rdata = norm_pend[31:0];
      W_FPHI:  bus_rdata = fast_pend[63:32];
      W_FPLO:  bus_rdata = fast_pend[31:0];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic [6:0]  addr,
  input logic [31:0] wdata,
  input logic        normal_irq,
  input logic        fast_irq,
  input logic [63:0] en_q,
  input logic [63:0] norm_pend,
  input logic [63:0] fast_pend,
  input logic [4:0]  mask_q,
  input logic [255:0] prio_q,
  input logic        nvec_valid,
  input logic [5:0]  nvec_num,
  input logic        fvec_valid,
  input logic [5:0]  fvec_num
);
  assert_nirq_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    normal_irq == nvec_valid);

  assert_firq_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fast_irq == fvec_valid);

  assert_nwin_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nvec_valid |-> norm_pend[nvec_num]);

  assert_fwin_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fvec_valid |-> fast_pend[fvec_num]);

  assert_class_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_pend & fast_pend) == 64'd0);

  assert_mask_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_valid && !mask_q[4]) |-> (prio_q[{nvec_num, 2'b00} +: 4] > mask_q[3:0]));

  assert_en_by_num_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 7'h08 && wdata[31:6] == 26'd0) |=> en_q[$past(wdata[5:0])]);

  assert_dis_by_num_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 7'h0C && wdata[31:6] == 26'd0) |=> !en_q[$past(wdata[5:0])]);
endmodule

bind dual_class_intc intc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .we         (bus_we),
  .addr       (bus_addr),
  .wdata      (bus_wdata),
  .normal_irq (normal_irq),
  .fast_irq   (fast_irq),
  .en_q       (en_q),
  .norm_pend  (norm_pend),
  .fast_pend  (fast_pend),
  .mask_q     (mask_q),
  .prio_q     (prio_q),
  .nvec_valid (nvec_valid),
  .nvec_num   (nvec_num),
  .fvec_valid (fvec_valid),
  .fvec_num   (fvec_num)
);

// File: tb/tb_dual_class_intc.sv
module tb_dual_class_intc;
  logic        clk;
  logic        rst_n;
  logic [63:0] src_i;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic        normal_irq;
  logic        fast_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dual_class_intc dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .normal_irq (normal_irq),
    .fast_irq   (fast_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 mask reset", 7'h04, 32'h1F);
    rd_chk("R1 enable lo reset", 7'h14, 32'h0);
    rd_chk("R1 enable hi reset", 7'h10, 32'h0);
    rd_chk("R1 prio word reset", 7'h2C, 32'h0);
    rd_chk("R1 normal vector reset", 7'h40, 32'hFFFF0000);
    rd_chk("R1 fast vector reset", 7'h44, 32'hFFFF0000);
    chk("R1 normal_irq reset", {31'd0, normal_irq}, 32'd0);
    chk("R1 fast_irq reset", {31'd0, fast_irq}, 32'd0);
  endtask

  task automatic t_enable_num;
    wr(7'h08, 32'd5);
    wr(7'h08, 32'd40);
    rd_chk("R2 enable-by-number low", 7'h14, 32'h00000020);
    rd_chk("R2 enable-by-number high", 7'h10, 32'h00000100);
    wr(7'h08, 32'd64);
    wr(7'h08, 32'd100);
    wr(7'h0C, 32'h00000045);
    rd_chk("R2 out of range ignored lo", 7'h14, 32'h00000020);
    rd_chk("R2 out of range ignored hi", 7'h10, 32'h00000100);
    wr(7'h0C, 32'd5);
    rd_chk("R2 disable-by-number", 7'h14, 32'h0);
    wr(7'h10, 32'h0);
  endtask

  task automatic t_prio;
    wr(7'h20, 32'h000000A0);          // word 7: source 57 priority A
    wr(7'h3C, 32'h00000300);          // word 0: source 2 priority 3
    rd_chk("R6 word 7 readback", 7'h20, 32'h000000A0);
    wr(7'h14, 32'h00000004);
    wr(7'h10, 32'h02000000);
    @(negedge clk);
    src_i[2]  = 1'b1;
    src_i[57] = 1'b1;
    rd_chk("R7 highest priority wins", 7'h40, 32'h00390000);
    chk("R8 normal_irq with no masking", {31'd0, normal_irq}, 32'd1);
  endtask

  task automatic t_tie;
    wr(7'h3C, 32'h00003300);          // sources 2 and 3 both priority 3
    wr(7'h08, 32'd3);
    @(negedge clk);
    src_i[57] = 1'b0;
    src_i[3]  = 1'b1;
    rd_chk("R7 tie goes to higher number", 7'h40, 32'h00030000);
  endtask

  task automatic t_mask;
    wr(7'h04, 32'h3);
    rd_chk("R8 level equal to floor masked", 7'h40, 32'hFFFF0000);
    chk("R8 normal_irq masked", {31'd0, normal_irq}, 32'd0);
    rd_chk("R5 pending ignores mask", 7'h5C, 32'h0000000C);
    wr(7'h04, 32'h2);
    rd_chk("R8 level above floor passes", 7'h40, 32'h00030000);
    wr(7'h04, 32'h1F);
  endtask

  task automatic t_level;
    @(negedge clk);
    src_i[2] = 1'b0;
    #1;
    rd_chk("R10 next source after drop", 7'h40, 32'h00030000);
    src_i[3] = 1'b0;
    #1;
    chk("R10 normal_irq drops with level", {31'd0, normal_irq}, 32'd0);
    rd_chk("R10 vector returns to none", 7'h40, 32'hFFFF0000);
  endtask

  task automatic t_fast;
    wr(7'h1C, 32'h00000024);          // sources 2 and 5 fast
    wr(7'h08, 32'd5);
    @(negedge clk);
    src_i[2] = 1'b1;
    src_i[5] = 1'b1;
    #1;
    chk("R9 fast_irq asserted", {31'd0, fast_irq}, 32'd1);
    chk("R3 fast source not on normal line", {31'd0, normal_irq}, 32'd0);
    rd_chk("R9 fast vector highest number", 7'h44, 32'h00050000);
    rd_chk("R5 fast pending low", 7'h64, 32'h00000024);
    rd_chk("R3 normal pending empty", 7'h5C, 32'h0);
    rd_chk("R3 normal vector none", 7'h40, 32'hFFFF0000);
    @(negedge clk);
    src_i[2] = 1'b0;
    src_i[5] = 1'b0;
    #1;
    chk("R9 fast_irq drops", {31'd0, fast_irq}, 32'd0);
  endtask

  task automatic t_force;
    wr(7'h50, 32'h80000000);          // force source 63
    wr(7'h08, 32'd63);
    @(negedge clk);
    src_i[33] = 1'b1;
    rd_chk("R4 forced source wins", 7'h40, 32'h003F0000);
    rd_chk("R4 raw inputs exclude force", 7'h48, 32'h00000002);
    rd_chk("R5 normal pending high", 7'h58, 32'h80000000);
    rd_chk("R4 force readback", 7'h50, 32'h80000000);
  endtask

  initial begin
    rst_n     = 1'b0;
    src_i     = '0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_num();
    t_prio();
    t_tie();
    t_mask();
    t_level();
    t_fast();
    t_force();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule